// File: doc/BRIEF.md
# Multiplexed Byte-Wide Memory Read Sequencer

This block performs asynchronous reads from an external byte-wide memory that shares one 16-bit bus for address and data. It runs on the peripheral clock. A request first places the full 16-bit address on the bus and pulses an address-latch strobe, so that an external latch captures the address. Four byte reads then follow. During each read the low address byte appears on the upper half of the bus, the memory drives the lower half, and the byte is sampled on the rising edge of the read strobe.

Timing is set by configuration inputs: the read strobe width, an optional hold cycle, a flash-recovery mode, and the polarity of the latch strobe. The four bytes are packed into a 32-bit result, which is presented with a one-cycle completion pulse. A new request is taken only while the block is idle.

Top module: `mux8_mem_reader`

## Requirements
- R1: A request (`rd_req` high at a clock edge) is accepted only while `busy` is low. `busy` is high from the cycle after acceptance through the `done` cycle. A request seen while busy, including in the `done` cycle, is ignored and does not disturb the current burst.
- R2: The latch strobe is active for exactly the two cycles that follow acceptance. During those cycles and the one after them, `bus_out` carries the full request address, with both `bus_oe_hi` and `bus_oe_lo` high.
- R3: With `ale_low`=0 the latch strobe is active high. With `ale_low`=1 it is active low. When not active, `ale` rests at the inactive level. The polarity is sampled at acceptance and holds for the whole burst.
- R4: `bus_oe_lo` drops from the second cycle after the latch strobe ends, and the first `rd_n` low cycle starts two cycles after the latch strobe ends (cycle 4 counted from 0 after acceptance).
- R5: Each `rd_n` low pulse lasts D cycles, where D = `strobe_len`, and a value of 0 gives a width of 1.
- R6: Exactly four `rd_n` pulses occur per request. During pulse k (k=0..3), `bus_out[15:8]` equals `(rd_addr[7:0]+k) mod 256` with `bus_oe_hi` high.
- R7: Between consecutive pulses `rd_n` is high for H+1 cycles, where H=1 if `hold_en` is set and H=0 otherwise.
- R8: The byte on `bus_in` is captured at the clock edge where `rd_n` returns high. Byte k goes into `rd_data[8k+7:8k]`.
- R9: `done` is high for one cycle, exactly H+F cycles after the last `rd_n` rising edge, where F=7 when `flash_en` is set and 0 otherwise. `rd_data` is valid in that cycle and stays unchanged until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_req | input | 1 | Read request |
| rd_addr | input | 16 | Start byte address |
| strobe_len | input | 5 | Read strobe width in cycles (0 means 1) |
| hold_en | input | 1 | Adds one address hold cycle after each read |
| flash_en | input | 1 | Adds seven recovery cycles after the last read |
| ale_low | input | 1 | Selects an active-low latch strobe |
| bus_in | input | 8 | Lower bus byte as driven by the memory |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| bus_out | output | 16 | Value driven onto the shared bus |
| bus_oe_hi | output | 1 | Drive enable for bus bits 15..8 |
| bus_oe_lo | output | 1 | Drive enable for bus bits 7..0 |
| busy | output | 1 | A burst is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Packed result of four bytes |

## Verification
The clash of interest is a new request that lands while the block is finishing: `rd_req` rises in the very cycle of the `done` pulse, or in the middle of a read strobe. The bench raises the request in those cycles with a different address and polarity, then follows the burst cycle by cycle. It expects the strobe pattern, the bus addresses and the packed word to match the first request, and `busy` to be low in the cycle after `done`. A second interaction, between the last byte capture and the commit of the result when the recovery tail is zero, is covered by random timing settings that include H=0 and F=0.

// File: rtl/mr_pkg.sv
// Package: shared phase encoding and sizing for the byte-wide memory reader.
// Assumes: the bus is exactly two bytes wide.
package mr_pkg;

    // Sequencer phases of one read burst.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_ALE    = 3'd1,
        PH_SETTLE = 3'd2,
        PH_STROBE = 3'd3,
        PH_GAP    = 3'd4,
        PH_DONE   = 3'd5
    } phase_t;

    localparam int ALE_CYC    = 2;  // latch strobe active cycles
    localparam int SETTLE_CYC = 2;  // cycles from latch end to first read strobe

endpackage

// File: rtl/mr_seq.sv
// Module: mr_seq
// Purpose: phase sequencer. It walks latch, settle, four strobes with gaps,
//          the recovery tail and the done cycle, and it latches the request
//          address and timing settings at acceptance.
// Assumes: a timing input may change at any time; only values seen at the
//          accepting edge are used for the burst.
module mr_seq
    import mr_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DUR_W     = 5,
    parameter int NBYTES    = 4,
    parameter int FLASH_CYC = 7,
    localparam int IDX_W    = (NBYTES > 1) ? $clog2(NBYTES) : 1,
    localparam int FL_W     = $clog2(FLASH_CYC + 2),
    localparam int CNT_W    = (DUR_W + 1 > FL_W) ? DUR_W + 1 : FL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DUR_W-1:0]  dur,
    input  logic              hold_en,
    input  logic              flash_en,
    input  logic              ale_low,
    output phase_t            phase,
    output logic [CNT_W-1:0]  cnt,
    output logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] base,
    output logic              pol,
    output logic              cap_en,
    output logic              fin
);

    phase_t            phase_q, phase_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  dur_m1_q;
    logic              hold_q, flash_q, pol_q;

    logic [CNT_W-1:0]  dur_m1_in;
    logic [CNT_W-1:0]  tail_len;
    logic              last_byte;

    // Strobe width minus one, with a zero field taken as width one.
    always_comb dur_m1_in = (dur == '0) ? '0 : CNT_W'(dur) - CNT_W'(1);

    // Recovery after the last strobe: hold term plus flash term.
    always_comb tail_len = CNT_W'(hold_q) + (flash_q ? CNT_W'(FLASH_CYC) : '0);

    always_comb last_byte = (idx_q == IDX_W'(NBYTES - 1));

    // Next-phase, counter and byte index selection.
    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        idx_d   = idx_q;
        unique case (phase_q)
            PH_IDLE: begin
                if (req) begin
                    phase_d = PH_ALE;
                    cnt_d   = CNT_W'(ALE_CYC - 1);
                    idx_d   = '0;
                end
            end
            PH_ALE: begin
                if (cnt_q == '0) begin
                    phase_d = PH_SETTLE;
                    cnt_d   = CNT_W'(SETTLE_CYC - 1);
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            PH_SETTLE: begin
                if (cnt_q == '0) begin
                    phase_d = PH_STROBE;
                    cnt_d   = dur_m1_q;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            PH_STROBE: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - CNT_W'(1);
                end else if (!last_byte) begin
                    phase_d = PH_GAP;
                    cnt_d   = CNT_W'(hold_q);
                end else if (tail_len == '0) begin
                    phase_d = PH_DONE;
                end else begin
                    phase_d = PH_GAP;
                    cnt_d   = tail_len - CNT_W'(1);
                end
            end
            PH_GAP: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - CNT_W'(1);
                end else if (last_byte) begin
                    phase_d = PH_DONE;
                end else begin
                    phase_d = PH_STROBE;
                    cnt_d   = dur_m1_q;
                    idx_d   = idx_q + IDX_W'(1);
                end
            end
            PH_DONE: phase_d = PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    // State registers for the phase walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
            idx_q   <= idx_d;
        end
    end

    // Settings capture: polarity tracks the input while idle, all freeze when busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            dur_m1_q <= '0;
            hold_q   <= 1'b0;
            flash_q  <= 1'b0;
            pol_q    <= 1'b0;
        end else if (phase_q == PH_IDLE) begin
            pol_q <= ale_low;
            if (req) begin
                base_q   <= addr;
                dur_m1_q <= dur_m1_in;
                hold_q   <= hold_en;
                flash_q  <= flash_en;
            end
        end
    end

    assign phase  = phase_q;
    assign cnt    = cnt_q;
    assign idx    = idx_q;
    assign base   = base_q;
    assign pol    = pol_q;
    assign cap_en = (phase_q == PH_STROBE) && (cnt_q == '0);
    assign fin    = (phase_d == PH_DONE) && (phase_q != PH_DONE);

endmodule

// File: rtl/mr_bus.sv
// Module: mr_bus
// Purpose: decodes the sequencer phase into strobe levels, bus drive values
//          and drive enables.
// Assumes: the bus is two bytes wide; outputs are decoded from registered state.
module mr_bus
    import mr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 6,
    parameter int IDX_W  = 2
) (
    input  phase_t            phase,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [IDX_W-1:0]  idx,
    input  logic [ADDR_W-1:0] base,
    input  logic              pol,
    output logic              ale,
    output logic              rd_n,
    output logic [ADDR_W-1:0] bus_out,
    output logic              oe_hi,
    output logic              oe_lo
);

    logic             full_addr;
    logic [BYTE_W-1:0] byte_addr;

    // Full address is driven while latching and for one cycle after it.
    always_comb full_addr = (phase == PH_ALE) ||
                            ((phase == PH_SETTLE) && (cnt != '0));

    // Low address of the current byte, wrapping within the byte.
    always_comb byte_addr = base[BYTE_W-1:0] + BYTE_W'(idx);

    // Strobe levels; polarity inverts the latch strobe.
    always_comb begin
        ale  = (phase == PH_ALE) ^ pol;
        rd_n = (phase != PH_STROBE);
    end

    // Bus value and drive enables.
    always_comb begin
        oe_lo = full_addr;
        oe_hi = (phase == PH_ALE) || (phase == PH_SETTLE) ||
                (phase == PH_STROBE) || (phase == PH_GAP);
        if (full_addr)
            bus_out = base;
        else if (oe_hi)
            bus_out = {byte_addr, {(ADDR_W - BYTE_W){1'b0}}};
        else
            bus_out = '0;
    end

endmodule

// File: rtl/mr_pack.sv
// Module: mr_pack
// Purpose: collects one byte per read strobe and commits the packed word
//          when the burst finishes.
// Assumes: cap_en marks the edge where the read strobe ends; fin marks the
//          edge entering the done cycle and may coincide with the last capture.
module mr_pack #(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 4,
    localparam int IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1,
    localparam int WORD_W = BYTE_W * NBYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] din,
    input  logic              fin,
    output logic [WORD_W-1:0] word
);

    logic [WORD_W-1:0] stage_q, stage_d;
    logic [WORD_W-1:0] word_q;

    // Per-slot merge of the incoming byte into the staging word.
    for (genvar s = 0; s < NBYTES; s++) begin : g_slot
        always_comb begin
            if (cap_en && (idx == IDX_W'(s)))
                stage_d[s*BYTE_W +: BYTE_W] = din;
            else
                stage_d[s*BYTE_W +: BYTE_W] = stage_q[s*BYTE_W +: BYTE_W];
        end
    end

    // Staging storage and result commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
            word_q  <= '0;
        end else begin
            stage_q <= stage_d;
            if (fin)
                word_q <= stage_d;
        end
    end

    assign word = word_q;

endmodule

// File: rtl/mux8_mem_reader.sv
// Module: mux8_mem_reader
// Purpose: top of the byte-wide multiplexed-bus memory reader. It connects the
//          sequencer, the bus decoder and the byte packer.
// Assumes: the external latch captures the address while the latch strobe is
//          active; the memory drives bus_in while bus_oe_lo is low.
module mux8_mem_reader
    import mr_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int BYTE_W    = 8,
    parameter int DUR_W     = 5,
    parameter int NBYTES    = 4,
    parameter int FLASH_CYC = 7,
    localparam int IDX_W    = (NBYTES > 1) ? $clog2(NBYTES) : 1,
    localparam int FL_W     = $clog2(FLASH_CYC + 2),
    localparam int CNT_W    = (DUR_W + 1 > FL_W) ? DUR_W + 1 : FL_W,
    localparam int WORD_W   = BYTE_W * NBYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DUR_W-1:0]  strobe_len,
    input  logic              hold_en,
    input  logic              flash_en,
    input  logic              ale_low,
    input  logic [BYTE_W-1:0] bus_in,
    output logic              ale,
    output logic              rd_n,
    output logic [ADDR_W-1:0] bus_out,
    output logic              bus_oe_hi,
    output logic              bus_oe_lo,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rd_data
);

    phase_t            phase;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] base;
    logic              ale_pol;
    logic              cap_en;
    logic              fin;

    mr_seq #(
        .ADDR_W    (ADDR_W),
        .DUR_W     (DUR_W),
        .NBYTES    (NBYTES),
        .FLASH_CYC (FLASH_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (rd_req),
        .addr     (rd_addr),
        .dur      (strobe_len),
        .hold_en  (hold_en),
        .flash_en (flash_en),
        .ale_low  (ale_low),
        .phase    (phase),
        .cnt      (cnt),
        .idx      (idx),
        .base     (base),
        .pol      (ale_pol),
        .cap_en   (cap_en),
        .fin      (fin)
    );

    mr_bus #(
        .ADDR_W (ADDR_W),
        .BYTE_W (BYTE_W),
        .CNT_W  (CNT_W),
        .IDX_W  (IDX_W)
    ) u_bus (
        .phase   (phase),
        .cnt     (cnt),
        .idx     (idx),
        .base    (base),
        .pol     (ale_pol),
        .ale     (ale),
        .rd_n    (rd_n),
        .bus_out (bus_out),
        .oe_hi   (bus_oe_hi),
        .oe_lo   (bus_oe_lo)
    );

    mr_pack #(
        .BYTE_W (BYTE_W),
        .NBYTES (NBYTES)
    ) u_pack (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (cap_en),
        .idx    (idx),
        .din    (bus_in),
        .fin    (fin),
        .word   (rd_data)
    );

    // Status decoded from the phase register.
    always_comb begin
        busy = (phase != PH_IDLE);
        done = (phase == PH_DONE);
    end

endmodule

// File: rtl/mr_reader_chk.sv
// Module: mr_reader_chk
// Purpose: temporal checks on the reader's pins, bound to the top module.
// Assumes: pol is the polarity captured inside the top.
module mr_reader_chk (
    input logic clk,
    input logic rst_n,
    input logic rd_req,
    input logic ale,
    input logic pol,
    input logic rd_n,
    input logic bus_oe_hi,
    input logic bus_oe_lo,
    input logic busy,
    input logic done
);

    // R2: the full address is driven whenever the latch strobe is active.
    a_r2_addr_on_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (ale ^ pol) |-> (bus_oe_hi && bus_oe_lo));

    // R4: the lower byte is released during every read strobe.
    a_r4_low_free_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !bus_oe_lo);

    // R6: the upper byte carries an address during every read strobe.
    a_r6_high_driven_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> bus_oe_hi);

    // R5: a read strobe never overlaps the latch strobe.
    a_r5_no_strobe_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !(ale ^ pol));

    // R9: done lasts one cycle and is followed by idle.
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R1: an idle request makes the block busy on the next cycle.
    a_r1_accept_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && rd_req) |=> busy);

    // R3: polarity is frozen while a burst runs.
    a_r3_pol_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(pol));

endmodule

bind mux8_mem_reader mr_reader_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (rd_req),
    .ale       (ale),
    .pol       (ale_pol),
    .rd_n      (rd_n),
    .bus_oe_hi (bus_oe_hi),
    .bus_oe_lo (bus_oe_lo),
    .busy      (busy),
    .done      (done)
);

// File: tb/test_mux8_mem_reader.sv
module test_mux8_mem_reader;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_req = 1'b0;
    logic [15:0] rd_addr = '0;
    logic [4:0]  strobe_len = '0;
    logic        hold_en = 1'b0;
    logic        flash_en = 1'b0;
    logic        ale_low = 1'b0;
    logic [7:0]  bus_in;
    logic        ale, rd_n, bus_oe_hi, bus_oe_lo, busy, done;
    logic [15:0] bus_out;
    logic [31:0] rd_data;
    logic [7:0]  salt = 8'h00;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    mux8_mem_reader i_mux8_mem_reader (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
        .strobe_len(strobe_len), .hold_en(hold_en), .flash_en(flash_en),
        .ale_low(ale_low), .bus_in(bus_in), .ale(ale), .rd_n(rd_n),
        .bus_out(bus_out), .bus_oe_hi(bus_oe_hi), .bus_oe_lo(bus_oe_lo),
        .busy(busy), .done(done), .rd_data(rd_data)
    );

    // Memory model content for a low address byte.
    function automatic logic [7:0] mem_byte(input logic [7:0] a, input logic [7:0] s);
        logic [15:0] p;
        p = 16'(a) * 16'd29;
        return p[7:0] ^ s ^ 8'hA5;
    endfunction

    // Memory drives the lower byte only when the reader releases it.
    always_comb bus_in = bus_oe_lo ? 8'h3C : mem_byte(bus_out[15:8], salt);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One burst with the bench stepping every cycle. poke_win >= 0 raises a
    // competing request in that window.
    task automatic run_read(input logic [15:0] a, input logic [4:0] d, input bit h,
                            input bit f, input bit pol, input int poke_win);
        int de, hh, tail, done_win, sk;
        logic [31:0] exp_word;
        bit exp_ale, exp_rlow, exp_olo, in_rd;
        logic [7:0] exp_hi;
        de   = (d == 0) ? 1 : int'(d);
        hh   = h ? 1 : 0;
        tail = hh + (f ? 7 : 0);
        done_win = 4 + 3 * (de + hh + 1) + de + tail;
        exp_word = '0;
        for (int j = 0; j < 4; j++)
            exp_word[j*8 +: 8] = mem_byte(a[7:0] + 8'(j), salt);

        @(negedge clk);
        ale_low = pol;
        @(negedge clk);
        chk(ale == pol, "R3 idle latch level", 32'(ale), 32'(pol));
        chk(!busy, "R1 idle before request", 32'(busy), 0);
        rd_addr = a; strobe_len = d; hold_en = h; flash_en = f; rd_req = 1'b1;
        @(posedge clk);
        for (int k = 0; k <= done_win + 1; k++) begin
            @(negedge clk);
            rd_req = (k == poke_win);
            if (k == poke_win) begin
                rd_addr = ~a; ale_low = ~pol; strobe_len = d + 5'd3;
            end
            exp_ale  = (k < 2);
            exp_olo  = (k < 3);
            exp_rlow = 1'b0;
            exp_hi   = 8'h00;
            for (int j = 0; j < 4; j++) begin
                sk = 4 + j * (de + hh + 1);
                in_rd = (k >= sk) && (k < sk + de);
                if (in_rd) begin
                    exp_rlow = 1'b1;
                    exp_hi   = a[7:0] + 8'(j);
                end
            end
            chk((ale ^ pol) == exp_ale, "R2 R3 latch strobe", 32'(ale), 32'(exp_ale ^ pol));
            chk(bus_oe_lo == exp_olo, "R4 low byte enable", 32'(bus_oe_lo), 32'(exp_olo));
            chk((!rd_n) == exp_rlow, "R5 R7 read strobe", 32'(rd_n), 32'(!exp_rlow));
            if (exp_ale)
                chk(bus_out == a && bus_oe_hi, "R2 full address", 32'(bus_out), 32'(a));
            if (exp_rlow)
                chk(bus_out[15:8] == exp_hi && bus_oe_hi, "R6 byte address",
                    32'(bus_out[15:8]), 32'(exp_hi));
            chk(done == (k == done_win), "R9 done timing", 32'(done), 32'(k == done_win));
            chk(busy == (k <= done_win), "R1 busy span", 32'(busy), 32'(k <= done_win));
            if (k == done_win)
                chk(rd_data == exp_word, "R8 packed data", rd_data, exp_word);
        end
        rd_req = 1'b0;
        ale_low = pol;
        @(negedge clk);
        chk(rd_data == exp_word, "R9 result held", rd_data, exp_word);
        chk(!busy, "R1 competing request ignored", 32'(busy), 0);
    endtask

    // Watchdog: a hung run is a failure and still reaches the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!busy && !done && rd_n && !ale && !bus_oe_hi && !bus_oe_lo,
            "R1 reset state", {busy, done, rd_n, ale, bus_oe_hi, bus_oe_lo}, 32'b001000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_data == 32'h0, "R8 reset data", rd_data, 0);

        // Directed corners.
        salt = 8'h11; run_read(16'h12FE, 5'd0, 1'b0, 1'b0, 1'b0, -1); // R5 zero width, R6 wrap
        salt = 8'h22; run_read(16'hA5F0, 5'd3, 1'b1, 1'b0, 1'b1, 6);  // R3 active low, R1 poke
        salt = 8'h33; run_read(16'h0001, 5'd31, 1'b1, 1'b1, 1'b0, -1); // R9 longest tail
        salt = 8'h44; run_read(16'hFFFF, 5'd1, 1'b0, 1'b1, 1'b1, -1);
        begin
            int dw;
            dw = 4 + 3 * (2 + 0 + 1) + 2 + 0;
            salt = 8'h55; run_read(16'h4321, 5'd2, 1'b0, 1'b0, 1'b0, dw); // R1 request in done cycle
        end

        // Constrained random bursts.
        for (int n = 0; n < 40; n++) begin
            logic [15:0] ra;
            logic [4:0]  rd;
            bit rh, rf, rp;
            int pw;
            ra = 16'($urandom);
            rd = 5'($urandom_range(0, 12));
            rh = 1'($urandom);
            rf = 1'($urandom);
            rp = 1'($urandom);
            pw = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 20)) : -1;
            salt = 8'($urandom);
            run_read(ra, rd, rh, rf, rp, pw);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule